// File: doc/BRIEF.md
# CAN Message Object Status Bank

This block keeps an eight-bit status byte and a four-bit length code for each of a set of CAN message objects (15 by default). It also decides which object the protocol engine serves. When several objects are armed to transmit, the lowest-numbered one is the producer. When a received frame is accepted by several armed receivers, the lowest-numbered one is the object that gets updated. Frame coding and acceptance filtering happen elsewhere: the block only sees the resulting enable and hit vectors, the event pulses and the received length code.

The protocol engine raises single-cycle event pulses: transmit done, receive done, and bit, stuff, CRC, form and acknowledge errors. A direction input tells the bank whether the engine is transmitting or receiving at that moment. From this the bank routes each event to the producer or to the updated object and latches it as a sticky flag. Software uses a small write/read port. It can preload the length code it expects for an object, and it clears flags by writing the whole status byte back. A combined interrupt request is raised while any enabled object holds an event flag.

Top module: `ostat_bank`

## Requirements
- R1: Status byte layout, MSB first: bit 7 length-code warning, bit 6 transmit done, bit 5 receive done, bit 4 bit error, bit 3 stuff error, bit 2 CRC error, bit 1 form error, bit 0 acknowledge error.
- R2: `tx_valid` is high exactly when any `tx_en` bit is set, and `tx_idx` is then the lowest set index.
- R3: `rx_valid` is high exactly when `hit_vec & rx_en` is non-zero, and `rx_idx` is then its lowest set index.
- R4: `ev_rxok` with `rx_valid` sets bit 5 of object `rx_idx` and always replaces its length code with `rx_dlc`.
- R5: On such a receive, bit 7 is set if `rx_dlc` differs from the length code stored before the edge. A match leaves bit 7 unchanged.
- R6: `ev_txok` sets bit 6 of the producer. `ev_bit_err` sets bit 4 of the producer only while `ev_dir`=1. A bit error while `ev_dir`=0, or with no producer, changes nothing.
- R7: Stuff, CRC, form and acknowledge errors set bits 3, 2, 1 and 0 of the producer when `ev_dir`=1, or of the updated receiver when `ev_dir`=0. With no such object they are dropped.
- R8: A status write (`wr_en`=1, `wr_sel_dlc`=0) to object `wr_obj` ANDs the stored byte with `wr_data`. It never sets a bit. Without a write, set flags stay set. Writes with `wr_obj` >= 15 are ignored.
- R9: If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R10: A length-code write (`wr_en`=1, `wr_sel_dlc`=1) loads `wr_data[3:0]` into the length code of `wr_obj`. A receive to the same object in the same cycle takes precedence.
- R11: `irq` is high exactly when some object has its `int_en` bit set and any of its status bits 6..0 set.
- R12: After reset every status byte and length code is zero, and `irq` is low.
- R13: `rd_stat` and `rd_dlc` show the stored values of object `rd_obj` in the same cycle. They read zero when `rd_obj` >= 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 15 | Per-object transmit arm |
| rx_en | input | 15 | Per-object receive arm |
| hit_vec | input | 15 | Acceptance hits of the current received frame |
| int_en | input | 15 | Per-object interrupt enable |
| ev_dir | input | 1 | 1 = engine transmitting, 0 = receiving |
| ev_txok | input | 1 | Transmit completed pulse |
| ev_rxok | input | 1 | Receive completed pulse |
| ev_bit_err | input | 1 | Bit error pulse |
| ev_stuff_err | input | 1 | Stuff error pulse |
| ev_crc_err | input | 1 | CRC error pulse |
| ev_form_err | input | 1 | Form error pulse |
| ev_ack_err | input | 1 | Acknowledge error pulse |
| rx_dlc | input | 4 | Received length code |
| wr_en | input | 1 | Register write strobe |
| wr_sel_dlc | input | 1 | 0 = status write, 1 = length-code write |
| wr_obj | input | 4 | Object addressed by a write |
| wr_data | input | 8 | Write data |
| rd_obj | input | 4 | Object addressed by the read port |
| rd_stat | output | 8 | Status byte of `rd_obj` |
| rd_dlc | output | 4 | Length code of `rd_obj` |
| tx_idx | output | 4 | Selected producer index |
| tx_valid | output | 1 | A producer exists |
| rx_idx | output | 4 | Index of the object a receive updates |
| rx_valid | output | 1 | A receiving object exists |
| stat_flat | output | 120 | All status bytes, object i at bits 8i+7..8i |
| dlc_flat | output | 60 | All length codes, object i at bits 4i+3..4i |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives several armed objects at once and confirms that the lowest index wins for both directions. A design with a reversed priority scan would serve the highest object or update the wrong status byte. It puts a clear and a set of the same flag in one cycle, and a design that lets the write win loses the event. It sends receives with matching and with mismatched length codes. Getting this wrong either misses the warning or fails to overwrite the stored code. It also raises bit errors while receiving, and a design that records them there marks a receiver that never drove the bus. Random traffic also writes to the unused address 15 and reads from it, so aliasing onto a real object shows up as a status mismatch.

// File: rtl/ostat_pkg.sv
package ostat_pkg;
  localparam int STAT_W = 8;
  localparam int DLC_W  = 4;

  // status byte bit positions (software decodes these)
  localparam int B_DLCW = 7;
  localparam int B_TXOK = 6;
  localparam int B_RXOK = 5;
  localparam int B_BERR = 4;
  localparam int B_SERR = 3;
  localparam int B_CERR = 2;
  localparam int B_FERR = 1;
  localparam int B_AERR = 0;

  typedef struct packed {
    logic txok;
    logic rxok;
    logic berr;
    logic serr;
    logic cerr;
    logic ferr;
    logic aerr;
  } ev_t;
endpackage

// File: rtl/ostat_lowpick.sv
module ostat_lowpick #(
  parameter int N = 15,
  parameter int W = 4
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] idx,
  output logic         valid
);
  always_comb begin
    idx   = '0;
    valid = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx   = W'(i);
        valid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ostat_cell.sv
module ostat_cell
  import ostat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_tx,
  input  logic              sel_rx,
  input  logic              ev_dir,
  input  ev_t               ev,
  input  logic [DLC_W-1:0]  rx_dlc,
  input  logic              wr_stat,
  input  logic              wr_dlc,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] stat,
  output logic [DLC_W-1:0]  dlc
);
  logic [STAT_W-1:0] stat_q, stat_d, set_v;
  logic [DLC_W-1:0]  dlc_q, dlc_d;
  logic              stat_en, dlc_en, err_tgt, rx_done;

  always_comb begin
    rx_done = sel_rx & ev.rxok;
    err_tgt = ev_dir ? sel_tx : sel_rx;
    set_v   = '0;
    set_v[B_TXOK] = sel_tx & ev.txok;
    set_v[B_BERR] = sel_tx & ev_dir & ev.berr;
    set_v[B_RXOK] = rx_done;
    set_v[B_DLCW] = rx_done & (rx_dlc != dlc_q);
    set_v[B_SERR] = err_tgt & ev.serr;
    set_v[B_CERR] = err_tgt & ev.cerr;
    set_v[B_FERR] = err_tgt & ev.ferr;
    set_v[B_AERR] = err_tgt & ev.aerr;
    stat_en = wr_stat | (|set_v);
    stat_d  = (wr_stat ? (stat_q & wr_data) : stat_q) | set_v;
    dlc_en  = rx_done | wr_dlc;
    dlc_d   = rx_done ? rx_dlc : wr_data[DLC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dlc_q <= '0;
    else if (dlc_en) dlc_q <= dlc_d;
  end

  assign stat = stat_q;
  assign dlc  = dlc_q;
endmodule

// File: rtl/ostat_bank.sv
module ostat_bank
  import ostat_pkg::*;
#(
  parameter int NOBJ = 15,
  parameter int IDXW = $clog2(NOBJ)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NOBJ-1:0]         tx_en,
  input  logic [NOBJ-1:0]         rx_en,
  input  logic [NOBJ-1:0]         hit_vec,
  input  logic [NOBJ-1:0]         int_en,
  input  logic                    ev_dir,
  input  logic                    ev_txok,
  input  logic                    ev_rxok,
  input  logic                    ev_bit_err,
  input  logic                    ev_stuff_err,
  input  logic                    ev_crc_err,
  input  logic                    ev_form_err,
  input  logic                    ev_ack_err,
  input  logic [DLC_W-1:0]        rx_dlc,
  input  logic                    wr_en,
  input  logic                    wr_sel_dlc,
  input  logic [IDXW-1:0]         wr_obj,
  input  logic [STAT_W-1:0]       wr_data,
  input  logic [IDXW-1:0]         rd_obj,
  output logic [STAT_W-1:0]       rd_stat,
  output logic [DLC_W-1:0]        rd_dlc,
  output logic [IDXW-1:0]         tx_idx,
  output logic                    tx_valid,
  output logic [IDXW-1:0]         rx_idx,
  output logic                    rx_valid,
  output logic [NOBJ*STAT_W-1:0]  stat_flat,
  output logic [NOBJ*DLC_W-1:0]   dlc_flat,
  output logic                    irq
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  ev_t               ev;
  logic [NOBJ-1:0]   rx_req, flag_any;
  logic [STAT_W-1:0] stat_a [NOBJ];
  logic [DLC_W-1:0]  dlc_a  [NOBJ];

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign ev     = '{txok: ev_txok, rxok: ev_rxok, berr: ev_bit_err, serr: ev_stuff_err,
                    cerr: ev_crc_err, ferr: ev_form_err, aerr: ev_ack_err};
  assign rx_req = hit_vec & rx_en;

  ostat_lowpick #(.N(NOBJ), .W(IDXW)) u_txpick (.req(tx_en),  .idx(tx_idx), .valid(tx_valid));
  ostat_lowpick #(.N(NOBJ), .W(IDXW)) u_rxpick (.req(rx_req), .idx(rx_idx), .valid(rx_valid));

  for (genvar g = 0; g < NOBJ; g++) begin : g_obj
    logic is_wr;
    assign is_wr = wr_en && (wr_obj == IDXW'(g));
    ostat_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .sel_tx  (tx_valid && (tx_idx == IDXW'(g))),
      .sel_rx  (rx_valid && (rx_idx == IDXW'(g))),
      .ev_dir  (ev_dir),
      .ev      (ev),
      .rx_dlc  (rx_dlc),
      .wr_stat (is_wr && !wr_sel_dlc),
      .wr_dlc  (is_wr && wr_sel_dlc),
      .wr_data (wr_data),
      .stat    (stat_a[g]),
      .dlc     (dlc_a[g])
    );
    assign stat_flat[g*STAT_W +: STAT_W] = stat_a[g];
    assign dlc_flat[g*DLC_W +: DLC_W]    = dlc_a[g];
    assign flag_any[g] = int_en[g] & (|stat_a[g][B_TXOK:0]);
  end

  assign irq = |flag_any;

  always_comb begin
    rd_stat = '0;
    rd_dlc  = '0;
    for (int i = 0; i < NOBJ; i++) begin
      if (rd_obj == IDXW'(i)) begin
        rd_stat = stat_a[i];
        rd_dlc  = dlc_a[i];
      end
    end
  end
endmodule

// File: rtl/ostat_bank_chk.sv
module ostat_bank_chk #(
  parameter int NOBJ = 15,
  parameter int IDXW = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NOBJ-1:0]     tx_en,
  input logic [NOBJ-1:0]     rx_en,
  input logic [NOBJ-1:0]     hit_vec,
  input logic [NOBJ-1:0]     int_en,
  input logic                ev_dir,
  input logic                ev_rxok,
  input logic [3:0]          rx_dlc,
  input logic                wr_en,
  input logic                wr_sel_dlc,
  input logic [IDXW-1:0]     tx_idx,
  input logic                tx_valid,
  input logic [IDXW-1:0]     rx_idx,
  input logic                rx_valid,
  input logic [NOBJ*8-1:0]   stat_flat,
  input logic [NOBJ*4-1:0]   dlc_flat,
  input logic                irq
);
  logic [NOBJ-1:0] rx_req, low_tx, low_rx, berr_v;
  logic [3:0]      dlc_c [NOBJ];

  assign rx_req = hit_vec & rx_en;
  assign low_tx = tx_en  & ((NOBJ'(1) << tx_idx) - NOBJ'(1));
  assign low_rx = rx_req & ((NOBJ'(1) << rx_idx) - NOBJ'(1));

  for (genvar g = 0; g < NOBJ; g++) begin : g_un
    assign dlc_c[g]  = dlc_flat[g*4 +: 4];
    assign berr_v[g] = stat_flat[g*8 + 4];
  end

  assert_tx_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_en[tx_idx] && (low_tx == '0)));
  assert_tx_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en != '0) |-> tx_valid);
  assert_rx_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_req[rx_idx] && (low_rx == '0)));
  assert_dlc_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && ev_rxok) |=> (dlc_c[$past(rx_idx)] == $past(rx_dlc)));
  assert_berr_tx_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_dir |=> ((berr_v & ~$past(berr_v)) == '0));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_sel_dlc) |=> ((stat_flat & $past(stat_flat)) == $past(stat_flat)));
  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_flat == '0) || (int_en == '0)) |-> !irq);
endmodule

bind ostat_bank ostat_bank_chk #(.NOBJ(NOBJ), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tx_en(tx_en), .rx_en(rx_en), .hit_vec(hit_vec),
  .int_en(int_en), .ev_dir(ev_dir), .ev_rxok(ev_rxok), .rx_dlc(rx_dlc), .wr_en(wr_en),
  .wr_sel_dlc(wr_sel_dlc), .tx_idx(tx_idx), .tx_valid(tx_valid), .rx_idx(rx_idx),
  .rx_valid(rx_valid), .stat_flat(stat_flat), .dlc_flat(dlc_flat), .irq(irq)
);

// File: tb/sim_ostat_bank.sv
module sim_ostat_bank;
  localparam int NOBJ = 15;
  localparam int IDXW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [NOBJ-1:0] tx_en, rx_en, hit_vec, int_en;
  logic ev_dir, ev_txok, ev_rxok, ev_bit_err, ev_stuff_err, ev_crc_err, ev_form_err, ev_ack_err;
  logic [3:0] rx_dlc;
  logic wr_en, wr_sel_dlc;
  logic [IDXW-1:0] wr_obj, rd_obj;
  logic [7:0] wr_data;
  logic [7:0] rd_stat;
  logic [3:0] rd_dlc;
  logic [IDXW-1:0] tx_idx, rx_idx;
  logic tx_valid, rx_valid, irq;
  logic [NOBJ*8-1:0] stat_flat;
  logic [NOBJ*4-1:0] dlc_flat;

  ostat_bank u0 (.*);

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_stat [NOBJ];
  logic [3:0] m_dlc  [NOBJ];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int lowest(input logic [NOBJ-1:0] v);
    for (int i = 0; i < NOBJ; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic exp_irq();
    for (int i = 0; i < NOBJ; i++) if (int_en[i] && (m_stat[i][6:0] != 0)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic idle();
    tx_en = '0; rx_en = '0; hit_vec = '0; int_en = '0; ev_dir = 1'b0;
    ev_txok = 0; ev_rxok = 0; ev_bit_err = 0; ev_stuff_err = 0; ev_crc_err = 0;
    ev_form_err = 0; ev_ack_err = 0; rx_dlc = '0; wr_en = 0; wr_sel_dlc = 0;
    wr_obj = '0; wr_data = '0; rd_obj = '0;
  endtask

  task automatic check_state(input string tag);
    for (int i = 0; i < NOBJ; i++) begin
      chk(tag, 32'(stat_flat[i*8 +: 8]), 32'(m_stat[i]));
      chk(tag, 32'(dlc_flat[i*4 +: 4]),  32'(m_dlc[i]));
    end
  endtask

  // called just after a falling edge with inputs already driven
  task automatic cycle(input string tag);
    int ts, rs, tg;
    logic [7:0] ns [NOBJ];
    logic [3:0] nd [NOBJ];
    #1;
    ts = lowest(tx_en);
    rs = lowest(hit_vec & rx_en);
    chk("R2 tx_valid", 32'(tx_valid), 32'(ts >= 0));
    if (ts >= 0) chk("R2 tx_idx", 32'(tx_idx), 32'(ts));
    chk("R3 rx_valid", 32'(rx_valid), 32'(rs >= 0));
    if (rs >= 0) chk("R3 rx_idx", 32'(rx_idx), 32'(rs));
    chk("R13 rd_stat", 32'(rd_stat), (rd_obj < NOBJ) ? 32'(m_stat[rd_obj]) : 32'd0);
    chk("R13 rd_dlc",  32'(rd_dlc),  (rd_obj < NOBJ) ? 32'(m_dlc[rd_obj])  : 32'd0);
    chk("R11 irq", 32'(irq), 32'(exp_irq()));
    for (int i = 0; i < NOBJ; i++) begin ns[i] = m_stat[i]; nd[i] = m_dlc[i]; end
    if (wr_en && wr_obj < NOBJ) begin
      if (wr_sel_dlc) nd[wr_obj] = wr_data[3:0];
      else            ns[wr_obj] = ns[wr_obj] & wr_data;
    end
    if (ts >= 0) begin
      if (ev_txok) ns[ts][6] = 1'b1;
      if (ev_dir && ev_bit_err) ns[ts][4] = 1'b1;
    end
    if (rs >= 0 && ev_rxok) begin
      ns[rs][5] = 1'b1;
      if (rx_dlc != m_dlc[rs]) ns[rs][7] = 1'b1;
      nd[rs] = rx_dlc;
    end
    tg = ev_dir ? ts : rs;
    if (tg >= 0) begin
      if (ev_stuff_err) ns[tg][3] = 1'b1;
      if (ev_crc_err)   ns[tg][2] = 1'b1;
      if (ev_form_err)  ns[tg][1] = 1'b1;
      if (ev_ack_err)   ns[tg][0] = 1'b1;
    end
    @(posedge clk);
    for (int i = 0; i < NOBJ; i++) begin m_stat[i] = ns[i]; m_dlc[i] = nd[i]; end
    @(negedge clk);
    idle();
    check_state(tag);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h0C0FFEE));
    idle();
    rst_n = 1'b0;
    for (int i = 0; i < NOBJ; i++) begin m_stat[i] = '0; m_dlc[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R12 reset");
    chk("R12 irq", 32'(irq), 32'd0);

    // R10 preload expected length code 8 into object 3
    wr_en = 1; wr_sel_dlc = 1; wr_obj = 4'd3; wr_data = 8'h08; cycle("R10");
    rd_obj = 4'd3; #1 chk("R10 rd_dlc", 32'(rd_dlc), 32'h8); @(negedge clk);

    // R3/R4/R5 multi-hit, matching code
    rx_en = '1; hit_vec = 15'h0228; ev_rxok = 1; rx_dlc = 4'd8; cycle("R4");
    rd_obj = 4'd3; #1 chk("R5 match no warn", 32'(rd_stat), 32'h20); @(negedge clk);
    rd_obj = 4'd5; #1 chk("R3 higher hit untouched", 32'(rd_stat), 32'h00); @(negedge clk);

    // R5 mismatch sets warning and overwrites
    rx_en = '1; hit_vec = 15'h0008; ev_rxok = 1; rx_dlc = 4'd2; cycle("R5");
    rd_obj = 4'd3; #1 chk("R5 warn", 32'(rd_stat), 32'hA0); chk("R4 dlc", 32'(rd_dlc), 32'h2);
    @(negedge clk);

    // R6/R1 producer events, lowest of 6 and 11
    tx_en = 15'h0840; ev_dir = 1; ev_txok = 1; ev_bit_err = 1; cycle("R6");
    rd_obj = 4'd6; #1 chk("R1 layout txok+berr", 32'(rd_stat), 32'h50); @(negedge clk);

    // R6 bit error while receiving is dropped
    tx_en = 15'h0001; ev_dir = 0; ev_bit_err = 1; cycle("R6 rx berr");
    rd_obj = 4'd0; #1 chk("R6 no berr", 32'(rd_stat), 32'h00); @(negedge clk);

    // R9 clear and set in one cycle
    tx_en = 15'h0040; ev_dir = 1; ev_txok = 1; wr_en = 1; wr_obj = 4'd6; wr_data = 8'h00;
    cycle("R9");
    rd_obj = 4'd6; #1 chk("R9 set wins", 32'(rd_stat), 32'h40); @(negedge clk);

    // R8 writing ones sets nothing
    wr_en = 1; wr_obj = 4'd0; wr_data = 8'hFF; cycle("R8");
    rd_obj = 4'd0; #1 chk("R8 no set", 32'(rd_stat), 32'h00); @(negedge clk);

    // R7 errors routed to the receiver
    rx_en = 15'h0200; hit_vec = 15'h0200; tx_en = 15'h0001; ev_dir = 0;
    ev_stuff_err = 1; ev_crc_err = 1; ev_form_err = 1; ev_ack_err = 1; cycle("R7");
    rd_obj = 4'd9; #1 chk("R7 rx errs", 32'(rd_stat), 32'h0F); @(negedge clk);

    // R10 receive beats simultaneous length write
    rx_en = 15'h0004; hit_vec = 15'h0004; ev_rxok = 1; rx_dlc = 4'd5;
    wr_en = 1; wr_sel_dlc = 1; wr_obj = 4'd2; wr_data = 8'h0C; cycle("R10 prio");
    rd_obj = 4'd2; #1 chk("R10 rx wins", 32'(rd_dlc), 32'h5); @(negedge clk);

    // R11 interrupt enable
    int_en = 15'h0040; rd_obj = 4'd15; cycle("R11");

    for (int n = 0; n < 3000; n++) begin
      tx_en   = NOBJ'($urandom & $urandom & $urandom);
      rx_en   = NOBJ'($urandom);
      hit_vec = NOBJ'($urandom & $urandom);
      int_en  = NOBJ'($urandom);
      ev_dir  = 1'($urandom);
      ev_txok = ($urandom % 4) == 0;
      ev_rxok = ($urandom % 3) == 0;
      ev_bit_err   = ($urandom % 6) == 0;
      ev_stuff_err = ($urandom % 7) == 0;
      ev_crc_err   = ($urandom % 7) == 0;
      ev_form_err  = ($urandom % 7) == 0;
      ev_ack_err   = ($urandom % 7) == 0;
      rx_dlc  = 4'($urandom);
      wr_en   = ($urandom % 3) == 0;
      wr_sel_dlc = 1'($urandom);
      wr_obj  = 4'($urandom);
      wr_data = 8'($urandom | $urandom);
      rd_obj  = 4'($urandom);
      cycle("R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule